// File: doc/BRIEF.md
# Vector Structure Access Micro-op Cracker

This block sits behind the instruction decoder and breaks one multi-register vector load or store of interleaved structures into an ordered series of simple micro-ops. A request names the direction, how many elements make up one structure, how many 64-bit vector registers take part, the element size, the alignment to check, the integer base register, the integer index register, the first vector register and the register stride. Once a legal request is accepted, the block presents one micro-op per cycle on a valid/ready output and goes idle after the final one is taken.

The micro-op stream is made of memory transfers (at most two, covering 8 or 16 bytes each), an optional base-register update, and register-shuffle operations that scatter or gather structure elements between a scratch register bank and the architectural vector registers. How many of each appear, and in what order, depends on the register count, the element count, the direction and the index register. Every micro-op except the final one is flagged for delayed commit, so the whole group retires together.

Top module: `vstruct_cracker`

## Requirements
- R1: A request is legal only when reqRegs is 1 to 4, reqElems is 1 to 4 and reqRegs is a whole multiple of reqElems; an illegal request is taken (reqReady high) but raises reqError for exactly the one cycle after the handshake, leaves busy low and produces no micro-op.
- R2: Memory micro-ops have kind 1 (load) or 2 (store) and carry the base register in regB; 1 register gives one 8-byte access at offset 0, 2 registers one 16-byte access at 0, 3 registers a 16-byte access at 0 then an 8-byte access at 16, 4 registers two 16-byte accesses at 0 and 16. Every micro-op carries reqSize in its size field.
- R3: The first memory micro-op carries reqAlign in its alignment field; the second always carries 3'b111 (no alignment check).
- R4: With reqIndex 15 there is no base update; with reqIndex 13 one kind-4 add-immediate micro-op adds reqRegs*8 (in the offset field); any other index gives one kind-3 add-register micro-op with regC = reqIndex; both have regA = regB = reqBase.
- R5: When reqElems is above 1, memory micro-op k (k = 0 or 1) uses data register 64 + 4k (scratch bank); otherwise it uses reqFirst*2 + 4k.
- R6: Shuffle micro-ops exist only when reqElems is above 1: kind 5 for stores, kind 6 for loads; span 8 for 4 elements, 6 for 3 elements, 4 for 2 elements; 2 elements with 4 registers gives two of them, otherwise one. Shuffle j uses scratch register 64 + 4j and vector register reqFirst*2 + 2j; loads put the vector register in regA and the scratch register in regB, stores the reverse.
- R7: Loads emit memory, then base update, then shuffles; stores emit shuffles, then memory, then base update.
- R8: Every micro-op but the final one of a request has delayed = 1 and last = 0; the final one has delayed = 0 and last = 1.
- R9: Shuffle micro-ops carry reqStride*2 in their stride field; every field a micro-op kind does not use is zero.
- R10: After reset busy, uopValid and reqError are low and reqReady is high; busy and uopValid rise the cycle after a legal request is taken and fall after the final micro-op is taken; reqReady is low while busy; all micro-op fields hold while uopValid is high and uopReady is low.
- R11: A legal request produces exactly (2 if reqRegs > 2 else 1) + (1 if reqIndex is not 15) + (reqRegs/reqElems if reqElems > 1) micro-ops and no more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqElems | input | 3 | Elements per structure |
| reqRegs | input | 3 | Vector registers involved |
| reqSize | input | 2 | Element size code |
| reqAlign | input | 3 | Alignment code for the first access |
| reqBase | input | 4 | Integer base register |
| reqIndex | input | 4 | Integer index register (15 none, 13 implied immediate) |
| reqFirst | input | 5 | First vector register |
| reqStride | input | 2 | Register stride |
| busy | output | 1 | Request in flight |
| reqError | output | 1 | One-cycle illegal-request flag |
| uopValid | output | 1 | Micro-op present |
| uopReady | input | 1 | Downstream takes the micro-op |
| uopKind | output | 3 | 1 load, 2 store, 3 add-register, 4 add-immediate, 5 interleave, 6 deinterleave |
| uopRegA | output | 7 | Destination / data register |
| uopRegB | output | 7 | Source / base register |
| uopRegC | output | 4 | Index register of an add-register |
| uopOffset | output | 6 | Byte offset or immediate |
| uopSpan | output | 5 | Bytes moved or registers shuffled |
| uopAlign | output | 3 | Alignment field |
| uopSize | output | 2 | Element size code |
| uopStride | output | 3 | Doubled register stride |
| uopDelayed | output | 1 | Delayed-commit flag |
| uopLast | output | 1 | Final micro-op of the request |

## Verification
The first micro-op of a legal request is due on the outputs in the cycle after the request handshake, and each later one in the cycle after its predecessor is taken; reqError is due in the cycle after an illegal handshake. The driver pushes the whole expected micro-op list before raising reqValid, and the monitor compares on the falling edge only when uopValid and uopReady are both high, so a stall simply delays the comparison instead of shifting it. Stalls are produced by a ready pattern that changes just after the rising edge, and during a stall the monitor also checks the held fields against the previous cycle.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  parameter int IREG_W  = 4;
  parameter int VREG_W  = 5;
  parameter int PREG_W  = 7;
  parameter int ALIGN_W = 3;
  parameter int OFS_W   = 6;
  parameter int SPAN_W  = 5;
  parameter int STEP_W  = 3;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_LOAD  = 3'd1,
    K_STORE = 3'd2,
    K_ADDR  = 3'd3,
    K_ADDI  = 3'd4,
    K_ILV   = 3'd5,
    K_DILV  = 3'd6
  } uopKind_e;

  typedef struct packed {
    logic load;
    logic step;
  } strobes_t;

  typedef struct packed {
    uopKind_e            kind;
    logic [PREG_W-1:0]   regA;
    logic [PREG_W-1:0]   regB;
    logic [IREG_W-1:0]   regC;
    logic [OFS_W-1:0]    offset;
    logic [SPAN_W-1:0]   span;
    logic [ALIGN_W-1:0]  align;
    logic [1:0]          size;
    logic [2:0]          stride;
    logic                delayed;
    logic                last;
  } uop_t;
endpackage

// File: rtl/vsc_ctrl.sv
module vsc_ctrl
  import vsc_pkg::*;
#(
  parameter int IDX_NONE = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        elemCnt,
  input  logic [2:0]        regCnt,
  input  logic [IREG_W-1:0] indexReg,
  input  logic              uopReady,
  output logic              reqReady,
  output logic              busy,
  output logic              uopValid,
  output logic              reqError,
  output logic [STEP_W-1:0] remaining,
  output strobes_t          strb
);
  logic              legal, accept;
  logic [STEP_W-1:0] memCnt, wbCnt, mixCnt, total;

  always_comb begin
    case (elemCnt)
      3'd1:    legal = (regCnt >= 3'd1) && (regCnt <= 3'd4);
      3'd2:    legal = (regCnt == 3'd2) || (regCnt == 3'd4);
      3'd3:    legal = (regCnt == 3'd3);
      3'd4:    legal = (regCnt == 3'd4);
      default: legal = 1'b0;
    endcase
  end

  assign memCnt = (regCnt > 3'd2) ? STEP_W'(2) : STEP_W'(1);
  assign wbCnt  = (indexReg != IREG_W'(IDX_NONE)) ? STEP_W'(1) : STEP_W'(0);
  assign mixCnt = (elemCnt > 3'd1) ? STEP_W'(regCnt / elemCnt) : STEP_W'(0);
  assign total  = memCnt + wbCnt + mixCnt;

  assign reqReady  = !busy;
  assign uopValid  = busy;
  assign accept    = reqValid && reqReady;
  assign strb.load = accept && legal;
  assign strb.step = uopValid && uopReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
      reqError  <= 1'b0;
    end else begin
      reqError <= accept && !legal;
      if (strb.load) begin
        busy      <= 1'b1;
        remaining <= total;
      end else if (strb.step) begin
        remaining <= remaining - STEP_W'(1);
        if (remaining == STEP_W'(1)) busy <= 1'b0;
      end
    end
  end

  AST_ERROR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> !busy); // R1
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (remaining != '0)); // R11
endmodule

// File: rtl/vsc_dpath.sv
module vsc_dpath
  import vsc_pkg::*;
#(
  parameter int                 TEMP_BASE = 64,
  parameter logic [ALIGN_W-1:0] ALIGN_OFF = '1,
  parameter int                 IDX_NONE  = 15,
  parameter int                 IDX_IMM   = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic               isStore,
  input  logic [2:0]         elemCnt,
  input  logic [2:0]         regCnt,
  input  logic [1:0]         sizeCode,
  input  logic [ALIGN_W-1:0] alignCode,
  input  logic [IREG_W-1:0]  baseReg,
  input  logic [IREG_W-1:0]  indexReg,
  input  logic [VREG_W-1:0]  firstReg,
  input  logic [1:0]         regStride,
  output uop_t               uop
);
  logic               rStore;
  logic [2:0]         rElem, rRegs;
  logic [1:0]         rSize, rStride;
  logic [ALIGN_W-1:0] rAlign;
  logic [IREG_W-1:0]  rBase, rIndex;
  logic [VREG_W-1:0]  rFirst;
  logic [STEP_W-1:0]  step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rStore <= 1'b0; rElem <= '0; rRegs <= '0; rSize <= '0; rStride <= '0;
      rAlign <= '0; rBase <= '0; rIndex <= '0; rFirst <= '0; step <= '0;
    end else if (strb.load) begin
      rStore <= isStore; rElem <= elemCnt; rRegs <= regCnt; rSize <= sizeCode;
      rStride <= regStride; rAlign <= alignCode; rBase <= baseReg;
      rIndex <= indexReg; rFirst <= firstReg; step <= '0;
    end else if (strb.step) begin
      step <= step + STEP_W'(1);
    end
  end

  // sequence layout: segment sizes and start positions
  logic [STEP_W-1:0] nMem, nWb, nMix, memLo, wbLo, mixLo, seqLen;
  logic              inMem, inWb, memSel, mixSel, lastStep;
  logic [PREG_W-1:0] rMid, vecBase, baseExt;

  assign nMem = (rRegs > 3'd2) ? STEP_W'(2) : STEP_W'(1);
  assign nWb  = (rIndex != IREG_W'(IDX_NONE)) ? STEP_W'(1) : STEP_W'(0);
  always_comb begin
    if (rElem <= 3'd1)                        nMix = STEP_W'(0);
    else if (rElem == 3'd2 && rRegs == 3'd4)  nMix = STEP_W'(2);
    else                                      nMix = STEP_W'(1);
  end
  assign memLo  = rStore ? nMix : STEP_W'(0);
  assign wbLo   = memLo + nMem;
  assign mixLo  = rStore ? STEP_W'(0) : (nMem + nWb);
  assign seqLen = nMem + nWb + nMix;

  assign inMem    = (step >= memLo) && (step < memLo + nMem);
  assign inWb     = (nWb != '0) && (step == wbLo);
  assign memSel   = (step - memLo) == STEP_W'(1);
  assign mixSel   = (step - mixLo) == STEP_W'(1);
  assign lastStep = (step == seqLen - STEP_W'(1));

  assign vecBase = PREG_W'({rFirst, 1'b0});
  assign rMid    = (rElem > 3'd1) ? PREG_W'(TEMP_BASE) : vecBase;
  assign baseExt = PREG_W'(rBase);

  logic [PREG_W-1:0] tmpReg, vecReg;
  assign tmpReg = PREG_W'(TEMP_BASE) + (mixSel ? PREG_W'(4) : PREG_W'(0));
  assign vecReg = vecBase + (mixSel ? PREG_W'(2) : PREG_W'(0));

  always_comb begin
    uop         = '0;
    uop.size    = rSize;
    uop.delayed = !lastStep;
    uop.last    = lastStep;
    if (inMem) begin
      uop.kind   = rStore ? K_STORE : K_LOAD;
      uop.regA   = rMid + (memSel ? PREG_W'(4) : PREG_W'(0));
      uop.regB   = baseExt;
      uop.offset = memSel ? OFS_W'(16) : OFS_W'(0);
      if (memSel) uop.span = (rRegs == 3'd4) ? SPAN_W'(16) : SPAN_W'(8);
      else        uop.span = (rRegs >= 3'd2) ? SPAN_W'(16) : SPAN_W'(8);
      uop.align  = memSel ? ALIGN_OFF : rAlign;
    end else if (inWb) begin
      uop.regA = baseExt;
      uop.regB = baseExt;
      if (rIndex == IREG_W'(IDX_IMM)) begin
        uop.kind   = K_ADDI;
        uop.offset = OFS_W'({rRegs, 3'b000});
      end else begin
        uop.kind = K_ADDR;
        uop.regC = rIndex;
      end
    end else begin
      uop.kind   = rStore ? K_ILV : K_DILV;
      uop.regA   = rStore ? tmpReg : vecReg;
      uop.regB   = rStore ? vecReg : tmpReg;
      uop.span   = (rElem == 3'd4) ? SPAN_W'(8) :
                   (rElem == 3'd3) ? SPAN_W'(6) : SPAN_W'(4);
      uop.stride = {rStride, 1'b0};
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load) |=> $stable(uop)); // R10
  AST_SECOND_NO_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    ((uop.kind == K_LOAD || uop.kind == K_STORE) && uop.offset != '0)
      |-> (uop.align == ALIGN_OFF)); // R3
endmodule

// File: rtl/vstruct_cracker.sv
module vstruct_cracker
  import vsc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqStore,
  input  logic [2:0]         reqElems,
  input  logic [2:0]         reqRegs,
  input  logic [1:0]         reqSize,
  input  logic [ALIGN_W-1:0] reqAlign,
  input  logic [IREG_W-1:0]  reqBase,
  input  logic [IREG_W-1:0]  reqIndex,
  input  logic [VREG_W-1:0]  reqFirst,
  input  logic [1:0]         reqStride,
  output logic               busy,
  output logic               reqError,
  output logic               uopValid,
  input  logic               uopReady,
  output logic [2:0]         uopKind,
  output logic [PREG_W-1:0]  uopRegA,
  output logic [PREG_W-1:0]  uopRegB,
  output logic [IREG_W-1:0]  uopRegC,
  output logic [OFS_W-1:0]   uopOffset,
  output logic [SPAN_W-1:0]  uopSpan,
  output logic [ALIGN_W-1:0] uopAlign,
  output logic [1:0]         uopSize,
  output logic [2:0]         uopStride,
  output logic               uopDelayed,
  output logic               uopLast
);
  strobes_t          strb;
  uop_t              uop;
  logic [STEP_W-1:0] remaining;

  vsc_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .elemCnt(reqElems), .regCnt(reqRegs),
    .indexReg(reqIndex), .uopReady, .reqReady, .busy, .uopValid,
    .reqError, .remaining, .strb
  );

  vsc_dpath u_dpath (
    .clk, .rstN, .strb, .isStore(reqStore), .elemCnt(reqElems),
    .regCnt(reqRegs), .sizeCode(reqSize), .alignCode(reqAlign),
    .baseReg(reqBase), .indexReg(reqIndex), .firstReg(reqFirst),
    .regStride(reqStride), .uop
  );

  assign uopKind    = uop.kind;
  assign uopRegA    = uop.regA;
  assign uopRegB    = uop.regB;
  assign uopRegC    = uop.regC;
  assign uopOffset  = uop.offset;
  assign uopSpan    = uop.span;
  assign uopAlign   = uop.align;
  assign uopSize    = uop.size;
  assign uopStride  = uop.stride;
  assign uopDelayed = uop.delayed;
  assign uopLast    = uop.last;

  AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> (uopLast == (remaining == STEP_W'(1)))); // R11
  AST_BUSY_TO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady && !uopLast) |=> busy); // R10
endmodule

// File: tb/test_vstruct_cracker.sv
module test_vstruct_cracker;
  import vsc_pkg::*;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqStore = 1'b0, uopReady = 1'b1;
  logic [2:0] reqElems = '0, reqRegs = '0;
  logic [1:0] reqSize = '0, reqStride = '0;
  logic [ALIGN_W-1:0] reqAlign = '0;
  logic [IREG_W-1:0] reqBase = '0, reqIndex = '0;
  logic [VREG_W-1:0] reqFirst = '0;
  logic reqReady, busy, reqError, uopValid, uopDelayed, uopLast;
  logic [2:0] uopKind, uopStride;
  logic [PREG_W-1:0] uopRegA, uopRegB;
  logic [IREG_W-1:0] uopRegC;
  logic [OFS_W-1:0] uopOffset;
  logic [SPAN_W-1:0] uopSpan;
  logic [ALIGN_W-1:0] uopAlign;
  logic [1:0] uopSize;

  vstruct_cracker i_vstruct_cracker (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  uop_t expQ[$];
  bit stallMode = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ready pattern changes just after the rising edge
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    uopReady = !stallMode || (cyc % 3 == 0);
  end

  function automatic uop_t gotUop();
    uop_t u;
    u.kind = uopKind_e'(uopKind); u.regA = uopRegA; u.regB = uopRegB;
    u.regC = uopRegC; u.offset = uopOffset; u.span = uopSpan;
    u.align = uopAlign; u.size = uopSize; u.stride = uopStride;
    u.delayed = uopDelayed; u.last = uopLast;
    return u;
  endfunction

  // monitor: scoreboard compare plus hold check
  bit heldValid = 1'b0;
  uop_t heldUop;
  always @(negedge clk) begin
    if (rstN) begin
      uop_t g, e;
      string tag;
      g = gotUop();
      if (heldValid && uopValid) check(g == heldUop, "R10 hold", 64'(g), 64'(heldUop));
      if (uopValid && uopReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11 extra micro-op", 64'(g), 64'(0));
        end else begin
          e = expQ.pop_front();
          check(g.kind == e.kind, "R7 kind order", 64'(g.kind), 64'(e.kind));
          if (e.kind == K_LOAD || e.kind == K_STORE) tag = "R2/R3/R5 memory fields";
          else if (e.kind == K_ADDR || e.kind == K_ADDI) tag = "R4 writeback fields";
          else tag = "R6/R9 shuffle fields";
          check(g == e, tag, 64'(g), 64'(e));
          check({g.delayed, g.last} == {e.delayed, e.last}, "R8 commit flags",
                64'({g.delayed, g.last}), 64'({e.delayed, e.last}));
        end
      end
      heldValid = uopValid && !uopReady;
      heldUop = g;
    end
  end

  task automatic pushU(input uopKind_e k, input int a, input int b, input int c,
                       input int ofs, input int span, input int al, input int sz, input int strd);
    uop_t u;
    u = '0;
    u.kind = k; u.regA = PREG_W'(a); u.regB = PREG_W'(b); u.regC = IREG_W'(c);
    u.offset = OFS_W'(ofs); u.span = SPAN_W'(span); u.align = ALIGN_W'(al);
    u.size = 2'(sz); u.stride = 3'(strd); u.delayed = 1'b1; u.last = 1'b0;
    expQ.push_back(u);
  endtask

  task automatic modelMem(input bit st, input int e, input int r, input int sz, input int al,
                          input int base, input int first);
    int mid;
    uopKind_e k;
    mid = (e > 1) ? 64 : first * 2;
    k = st ? K_STORE : K_LOAD;
    pushU(k, mid, base, 0, 0, (r >= 2) ? 16 : 8, al, sz, 0);
    if (r > 2) pushU(k, mid + 4, base, 0, 16, (r == 4) ? 16 : 8, 7, sz, 0);
  endtask

  task automatic modelWb(input int r, input int sz, input int base, input int idx);
    if (idx == 13) pushU(K_ADDI, base, base, 0, r * 8, 0, 0, sz, 0);
    else if (idx != 15) pushU(K_ADDR, base, base, idx, 0, 0, 0, sz, 0);
  endtask

  task automatic modelMix(input bit st, input int e, input int r, input int sz,
                          input int first, input int strd);
    int cnt, span;
    if (e > 1) begin
      cnt = (e == 2 && r == 4) ? 2 : 1;
      span = (e == 4) ? 8 : (e == 3) ? 6 : 4;
      for (int j = 0; j < cnt; j++) begin
        if (st) pushU(K_ILV, 64 + 4 * j, first * 2 + 2 * j, 0, 0, span, 0, sz, strd * 2);
        else    pushU(K_DILV, first * 2 + 2 * j, 64 + 4 * j, 0, 0, span, 0, sz, strd * 2);
      end
    end
  endtask

  task automatic request(input bit st, input int e, input int r, input int sz, input int al,
                         input int base, input int idx, input int first, input int strd);
    bit legal;
    uop_t u;
    legal = (r >= 1) && (r <= 4) && (e >= 1) && (e <= 4) && (r % e == 0);
    if (legal) begin
      if (st) begin
        modelMix(st, e, r, sz, first, strd); modelMem(st, e, r, sz, al, base, first); modelWb(r, sz, base, idx);
      end else begin
        modelMem(st, e, r, sz, al, base, first); modelWb(r, sz, base, idx); modelMix(st, e, r, sz, first, strd);
      end
      u = expQ.pop_back(); u.delayed = 1'b0; u.last = 1'b1; expQ.push_back(u);
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqStore = st; reqElems = 3'(e); reqRegs = 3'(r);
    reqSize = 2'(sz); reqAlign = 3'(al); reqBase = 4'(base); reqIndex = 4'(idx);
    reqFirst = 5'(first); reqStride = 2'(strd);
    @(negedge clk);
    reqValid = 1'b0;
    if (!legal) begin
      check(reqError && !uopValid && !busy, "R1 illegal flagged, nothing emitted",
            64'({reqError, uopValid, busy}), 64'(3'b100));
      @(negedge clk);
      check(!reqError && !uopValid, "R1 error lasts one cycle",
            64'({reqError, uopValid}), 64'(0));
    end else begin
      check(busy && uopValid && !reqReady && !reqError, "R10 busy after accept",
            64'({busy, uopValid, reqReady, reqError}), 64'(4'b1100));
      while (expQ.size() != 0) @(negedge clk);
      @(negedge clk);
      check(!busy && !uopValid && reqReady, "R11 done after exact count",
            64'({busy, uopValid, reqReady}), 64'(3'b001));
    end
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !uopValid && !reqError && reqReady, "R10 reset state",
          64'({busy, uopValid, reqError, reqReady}), 64'(4'b0001));
    request(0, 1, 1, 0, 2, 3, 15, 3, 1);   // single 8-byte load, no writeback
    request(0, 4, 4, 1, 5, 2, 13, 4, 1);   // R4 immediate writeback, 8-reg shuffle
    request(1, 3, 3, 2, 1, 6, 7, 9, 2);    // store, 6-reg shuffle, register writeback
    stallMode = 1'b1;
    request(0, 2, 4, 0, 3, 1, 15, 10, 2);  // two shuffles, stalled
    request(1, 1, 4, 3, 4, 8, 2, 20, 1);   // plain store of 4 registers, stalled
    stallMode = 1'b0;
    request(1, 2, 2, 1, 6, 5, 13, 1, 1);
    request(0, 2, 2, 2, 0, 12, 0, 31, 2);
    request(0, 1, 3, 0, 7, 4, 13, 0, 0);   // R5 direct target, 3 registers
    request(0, 3, 4, 0, 0, 1, 15, 0, 1);   // illegal: not a multiple
    request(1, 1, 0, 0, 0, 1, 15, 0, 1);   // illegal: zero registers
    request(0, 1, 5, 0, 0, 1, 15, 0, 1);   // illegal: five registers
    request(0, 0, 2, 0, 0, 1, 15, 0, 1);   // illegal: zero elements
    request(1, 4, 4, 2, 3, 14, 11, 2, 1);  // legal right after illegal
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R10 watchdog expired", 64'(1), 64'(0));
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule